// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block ends an I2C master transfer by producing the Stop condition on the bus, and it watches for another master fighting it while it does so. A one-cycle request starts the sequence. The block first pulls SDA low and keeps SCL low. It lets SCL go once it sees SDA low. It then waits for SCL to read high, so a slave or another master may stretch the clock for as long as it likes. After that it holds SDA low for one timed interval. It then lets SDA rise and, after a second timed interval, reads SDA back.

A high SDA at that point ends the sequence cleanly. The block pulses a done flag and sets a sticky Stop-seen status. A low SDA, or SCL going low during the first timed interval, means another master is driving the bus. In that case the block raises a collision flag, lets go of both lines at once and goes back to idle without signalling done.

Both bus inputs pass through a two-stage synchronizer before the sequencer reads them. Each timed interval lasts as many clocks as the reload value, and a reload of 0 is stretched to 1 clock. The block expects the master to be holding both lines low when the request arrives.

Top module: `i2c_stop_seq`

## Requirements
- R1: During and right after reset, both line enables are 0, `busy` is 0, and `stop_done`, `bus_coll` and `stop_seen` are 0. An enable of 1 means the line is pulled low; 0 means it is released.
- R2: A `stop_req` sampled high while idle sets `sda_oe`, `scl_oe` and `busy` to 1 from the next cycle on.
- R3: `scl_oe` drops only after the synchronized SDA reads 0. The synchronizer has two flip-flop stages, and the sequencer acts on the stage-two value one clock later.
- R4: After SCL is released, the block waits with no time limit until the synchronized SCL reads 1. It then keeps `sda_oe` at 1 for N more cycles, where N is the value on `reload` at that moment.
- R5: `sda_oe` then drops for N cycles, with N taken from `reload` again. If synchronized SDA reads 1 on the last of those cycles, `stop_done` is 1 for exactly one cycle, `stop_seen` becomes 1 and `busy` falls in that same cycle.
- R6: If synchronized SDA reads 0 on that last cycle, `bus_coll` becomes 1, `busy` falls, and neither `stop_done` nor `stop_seen` is set.
- R7: If synchronized SCL reads 0 during the interval in which SDA is still held low after SCL was released, the block aborts at once. `bus_coll` becomes 1, both enables go to 0 and `busy` falls. This check has priority over the interval's timeout.
- R8: A `reload` value of 0 gives timed intervals of one cycle, the same as a value of 1.
- R9: A `stop_req` that arrives while `busy` is 1 has no effect on the sequence.
- R10: `bus_coll` and `stop_seen` hold their value until the next accepted `stop_req`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to generate a Stop |
| reload | input | RW (8) | Length of each timed interval in clocks (0 acts as 1) |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| busy | output | 1 | Sequence in progress |
| stop_done | output | 1 | One-cycle pulse on clean completion |
| stop_seen | output | 1 | Sticky: last sequence completed cleanly |
| bus_coll | output | 1 | Sticky: last sequence was aborted by a collision |

## Verification
Two events can land on the same clock edge: the timeout of the SDA-low interval and an SCL-low sample. R7 says the collision wins. The bench makes this happen by pulling SCL low from the outside at several offsets inside that interval, including the last cycle, and with a one-cycle reload, where every sample falls on a timeout. A second pair is a new `stop_req` arriving on the very cycle in which a sequence finishes. The bench drives this by repeating requests while `busy` is high. For both pairs a behavioural bus-and-sequencer model decides the outcome, and the bench compares every output with that model on every clock.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SDA_LOW,
        ST_SCL_REL,
        ST_SETUP,
        ST_SDA_REL
    } stop_state_e;

    typedef struct packed {
        stop_state_e state;
        logic        done;
        logic        coll;
        logic        seen;
    } stop_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= '1;
                else        stage_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= '1;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_stop_timer.sv
module i2c_stop_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] eff_val;

    assign eff_val = (load_val == '0) ? ONE : load_val;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = eff_val;
        else if (tick && cnt_q > ONE) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == ONE);
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
    import i2c_stop_pkg::*;
#(
    parameter int RW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop_req,
    input  logic [RW-1:0] reload,
    input  logic          sda_in,
    input  logic          scl_in,
    output logic          sda_oe,
    output logic          scl_oe,
    output logic          busy,
    output logic          stop_done,
    output logic          stop_seen,
    output logic          bus_coll
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, sync_lines;
    logic             sda_s, scl_s;
    logic             tmr_load, tmr_tick, tmr_exp;
    stop_regs_t       r_d, r_q;

    assign raw_lines = {scl_in, sda_in};

    i2c_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    assign sda_s = sync_lines[0];
    assign scl_s = sync_lines[1];

    i2c_stop_timer #(.CW(RW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(reload),
        .tick    (tmr_tick),
        .expired (tmr_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (stop_req) begin
                    r_d.state = ST_SDA_LOW;
                    r_d.coll  = 1'b0;
                    r_d.seen  = 1'b0;
                end
            end
            ST_SDA_LOW: begin
                if (!sda_s) r_d.state = ST_SCL_REL;
            end
            ST_SCL_REL: begin
                if (scl_s) begin
                    r_d.state = ST_SETUP;
                    tmr_load  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (!scl_s) begin
                    r_d.coll  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (tmr_exp) begin
                    r_d.state = ST_SDA_REL;
                    tmr_load  = 1'b1;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            ST_SDA_REL: begin
                if (tmr_exp) begin
                    r_d.state = ST_IDLE;
                    if (sda_s) begin
                        r_d.done = 1'b1;
                        r_d.seen = 1'b1;
                    end else begin
                        r_d.coll = 1'b1;
                    end
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.done  <= 1'b0;
            r_q.coll  <= 1'b0;
            r_q.seen  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = (r_q.state == ST_SDA_LOW) || (r_q.state == ST_SCL_REL) ||
                       (r_q.state == ST_SETUP);
    assign scl_oe    = (r_q.state == ST_SDA_LOW);
    assign busy      = (r_q.state != ST_IDLE);
    assign stop_done = r_q.done;
    assign stop_seen = r_q.seen;
    assign bus_coll  = r_q.coll;
endmodule

// File: rtl/i2c_stop_seq_chk.sv
module i2c_stop_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic sda_oe,
    input logic scl_oe,
    input logic busy,
    input logic stop_done,
    input logic stop_seen,
    input logic bus_coll
);
    // R2: an idle request starts the sequence with both lines held low
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_req) |=> (busy && sda_oe && scl_oe));

    // R3: SCL is never held low once SDA has been released
    a_r3_scl_before_sda: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sda_oe) |-> !scl_oe);

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> !stop_done);

    // R5/R6: done comes with stop_seen, without collision, and ends busy
    a_r5_done_state: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> (stop_seen && !bus_coll && !busy));

    // R7: a collision releases both lines and ends busy
    a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (!busy && !sda_oe && !scl_oe));

    // R10: sticky flags change only while idle is left or busy falls
    a_r10_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !stop_req) |=> $stable(bus_coll) && $stable(stop_seen));
endmodule

bind i2c_stop_seq i2c_stop_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .busy     (busy),
    .stop_done(stop_done),
    .stop_seen(stop_seen),
    .bus_coll (bus_coll)
);

// File: tb/i2c_stop_seq_tb.sv
module i2c_stop_seq_tb;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_req = 1'b0;
    logic [RW-1:0] reload = '0;
    logic          f_sda = 1'b0;   // external master pulling SDA low
    logic          f_scl = 1'b0;   // external device pulling SCL low
    logic          sda_oe, scl_oe, busy, stop_done, stop_seen, bus_coll;
    logic          sda_line, scl_line;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = !(sda_oe | f_sda);
    assign scl_line = !(scl_oe | f_scl);

    i2c_stop_seq #(.RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
        .sda_in(sda_line), .scl_in(scl_line),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .busy(busy),
        .stop_done(stop_done), .stop_seen(stop_seen), .bus_coll(bus_coll)
    );

    // Behavioural reference: phase 0 idle, 1 wait SDA low, 2 wait SCL high,
    // 3 SDA-low interval, 4 SDA-high interval
    int   m_ph = 0;
    int   m_cnt = 0;
    bit   m_done = 0, m_coll = 0, m_seen = 0;
    bit   sq_sda[$];
    bit   sq_scl[$];
    bit   m_sda_oe, m_scl_oe, m_sda_line, m_scl_line, s_sda, s_scl;

    function automatic int eff_len(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_done = 0; m_coll = 0; m_seen = 0;
            sq_sda = '{1'b1, 1'b1};
            sq_scl = '{1'b1, 1'b1};
        end else begin
            m_sda_oe   = (m_ph == 1) || (m_ph == 2) || (m_ph == 3);
            m_scl_oe   = (m_ph == 1);
            m_sda_line = !(m_sda_oe || f_sda);
            m_scl_line = !(m_scl_oe || f_scl);
            s_sda = sq_sda[0];
            s_scl = sq_scl[0];
            m_done = 0;
            case (m_ph)
                0: if (stop_req) begin m_ph = 1; m_coll = 0; m_seen = 0; end
                1: if (!s_sda) m_ph = 2;
                2: if (s_scl) begin m_ph = 3; m_cnt = eff_len(int'(reload)); end
                3: begin
                    if (!s_scl) begin m_coll = 1; m_ph = 0; end
                    else if (m_cnt == 1) begin m_ph = 4; m_cnt = eff_len(int'(reload)); end
                    else m_cnt--;
                end
                4: begin
                    if (m_cnt == 1) begin
                        m_ph = 0;
                        if (s_sda) begin m_done = 1; m_seen = 1; end
                        else m_coll = 1;
                    end else m_cnt--;
                end
                default: m_ph = 0;
            endcase
            void'(sq_sda.pop_front());
            void'(sq_scl.pop_front());
            sq_sda.push_back(m_sda_line);
            sq_scl.push_back(m_scl_line);
        end
    end

    task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, nm, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            cmp("R2/R4/R8", "sda_oe", sda_oe, (m_ph == 1) || (m_ph == 2) || (m_ph == 3));
            cmp("R2/R3",    "scl_oe", scl_oe, m_ph == 1);
            cmp("R9",       "busy",   busy,   m_ph != 0);
            cmp("R5",       "stop_done", stop_done, m_done);
            cmp("R5/R10",   "stop_seen", stop_seen, m_seen);
            cmp("R6/R7/R10","bus_coll",  bus_coll,  m_coll);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic pulse_req();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_plain(input int rl);
        reload = RW'(rl);
        pulse_req();
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if ({sda_oe, scl_oe, busy, stop_done, stop_seen, bus_coll} !== 6'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %b expected 000000",
                     {sda_oe, scl_oe, busy, stop_done, stop_seen, bus_coll});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5: clean stops with several interval lengths
        run_plain(3);
        run_plain(1);
        run_plain(0);       // R8: zero reload acts as one
        run_plain(6);

        // R4: clock stretching by an external device before SCL reads high
        reload = 8'd2;
        f_scl = 1'b1;
        pulse_req();
        repeat (12) @(negedge clk);
        f_scl = 1'b0;
        wait_idle();

        // R6: another master keeps SDA low for the whole sequence
        f_sda = 1'b1;
        run_plain(3);
        f_sda = 1'b0;
        repeat (2) @(negedge clk);

        // R10: flags cleared on the next accepted request
        run_plain(2);

        // R7: SCL pulled low at several offsets inside the SDA-low interval
        for (int off = 7; off <= 16; off++) begin
            reload = 8'd8;
            pulse_req();
            repeat (off) @(negedge clk);
            f_scl = 1'b1;
            repeat (3) @(negedge clk);
            f_scl = 1'b0;
            wait_idle();
        end

        // R7 with one-cycle intervals: collision and timeout on the same edge
        for (int off = 4; off <= 9; off++) begin
            reload = 8'd0;
            pulse_req();
            repeat (off) @(negedge clk);
            f_scl = 1'b1;
            @(negedge clk);
            f_scl = 1'b0;
            wait_idle();
        end

        // R9: repeated requests while busy are ignored
        reload = 8'd4;
        stop_req = 1'b1;
        repeat (30) @(negedge clk);
        stop_req = 1'b0;
        wait_idle();
        reload = 8'd2;
        pulse_req();
        repeat (5) @(negedge clk);
        pulse_req();
        wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule